// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block sits beside a double-data-rate synchronous DRAM interface and watches its control pins on every rising clock edge. It turns each sampled cycle into a command code, raises a strobe for the command it saw, and keeps a per-bank picture of the device: whether each bank is idle, open, or in a read or write burst, and which row is open. Bursts are timed from a configured burst length, and auto-precharge is tracked, so each bank returns to idle after its burst when the command asked for it.

Precharge, refresh and illegal sequences are tracked as well. A precharge can close one bank or every bank, and it cuts short any burst in progress. A refresh closes every bank and reports the refresh address drawn from an internal counter. Commands that break the bank protocol raise a one-cycle violation flag. Monitors, memory-controller checkers and trace tools use the outputs to follow the device state without modelling it themselves.

Top module: `dram_cmd_tracker`

## Requirements
- R1: All outputs are registered and reflect the pins sampled at the previous rising edge. With `cs_n` high the cycle decodes as deselect (code 0): no strobe, no violation, and bank state changes only by bursts advancing. With `cs_n` low and `ras_n`, `cas_n`, `we_n` all high the cycle is a no-operation (code 1) with the same effect.
- R2: With `cs_n` low, the pins {ras_n,cas_n,we_n} decode as follows. 0,1,1 is activate (code 2). 1,0,1 is read (code 3). 1,0,0 is write (code 4). 0,1,0 is precharge (code 5). 0,0,1 with `cke` high is refresh (code 6). Every other pattern, including 0,0,1 with `cke` low, is code 7 and leaves all bank state untouched. `cmd_stb_o` bit 0 marks activate, bit 1 read, bit 2 write, bit 3 precharge and bit 4 refresh. At most one bit is set.
- R3: An activate to an idle bank moves it to the active state (1) and stores `addr_i` as that bank's open row.
- R4: A read or write to a non-idle bank puts it in the reading (2) or writing (3) state for BL/2 cycles, at two data beats per cycle. `bl_sel_i` 00 selects 2 beats, 01 selects 4 and 10 or 11 select 8. The bank then returns to active.
- R5: If `addr_i[10]` is high on the read or write, the bank returns to idle at the end of the burst, and its open row reads zero.
- R6: A precharge with `addr_i[10]` low closes only the bank on `ba_i`. With `addr_i[10]` high it closes every bank. A precharge to an idle bank has no effect and raises no violation.
- R7: A precharge to a bank in a burst ends the burst at once, and the bank shows idle in the next cycle.
- R8: A refresh leaves every bank idle, pulses `ref_req_o` for one cycle and shows on `ref_addr_o` the refresh address used. That address is 0 for the first refresh after reset and rises by one with each refresh.
- R9: `viol_o` is high for one cycle after any of three events: a read or write to an idle bank, an activate to a non-idle bank, or a refresh while any bank is non-idle. The offending read, write or activate is ignored, so state and open row are kept. The refresh is still carried out.
- R10: Bank b's state sits in `bank_state_o[2b+1:2b]` (0 idle, 1 active, 2 reading, 3 writing). Its open row sits in `open_row_o[13b+12:13b]` and is zero whenever the bank is idle.
- R11: While `rst` is high and after it, until the first command, the command code is 0, no strobe or violation is set, all banks are idle with row zero and `ref_addr_o` is zero.
- R12: A read or write to a bank already in a burst restarts the burst count with the new command's direction and auto-precharge option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| cke | input | 1 | Clock enable, qualifies refresh |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Row/column address; bit 10 is the precharge option |
| bl_sel_i | input | 2 | Burst length select (00=2, 01=4, else 8 beats) |
| cmd_o | output | 3 | Decoded command code of the previous cycle |
| cmd_stb_o | output | 5 | One strobe per command: act, read, write, precharge, refresh |
| bank_state_o | output | 8 | Two-bit state per bank |
| open_row_o | output | 52 | Thirteen-bit open row per bank |
| ref_req_o | output | 1 | One-cycle pulse per refresh |
| ref_addr_o | output | 15 | Refresh address of the most recent refresh |
| viol_o | output | 1 | One-cycle protocol violation flag |

## Verification
Every cycle, the assertions check several invariants. At most one strobe is set, and the violation flag appears only on commands that can violate. A deselect carries neither strobe nor violation. A refresh pulse always comes with every bank idle, and the refresh address moves only on a refresh. An idle bank always shows a zero row. Burst durations per length select, auto-precharge return, precharge-all against single-bank precharge and restarted bursts depend on command history. Only the bench can show these, by running its reference model beside the design through directed sequences and a long stretch of random pin activity.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int NUM_BANKS_DEF = 4;
    localparam int ROW_W_DEF     = 13;
    localparam int AP_BIT        = 10;
    localparam int N_STB         = 5;
    localparam int CNT_W         = 3;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_REF   = 3'd6,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_READ   = 2'd2,
        BK_WRITE  = 2'd3
    } bank_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } pins_t;

    // Clock cycles of a burst: two beats move per cycle.
    function automatic logic [CNT_W-1:0] burst_cycles(input logic [1:0] sel);
        case (sel)
            2'b00:   return CNT_W'(1);
            2'b01:   return CNT_W'(2);
            default: return CNT_W'(4);
        endcase
    endfunction

    function automatic logic [N_STB-1:0] cmd_strobe(input cmd_e c);
        logic [N_STB-1:0] s;
        s = '0;
        case (c)
            CMD_ACT:   s[0] = 1'b1;
            CMD_READ:  s[1] = 1'b1;
            CMD_WRITE: s[2] = 1'b1;
            CMD_PRE:   s[3] = 1'b1;
            CMD_REF:   s[4] = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/dct_decoder.sv
module dct_decoder
    import dct_pkg::*;
(
    input  pins_t pins_i,
    output cmd_e  cmd_o
);
    always_comb begin
        if (pins_i.cs_n) begin
            cmd_o = CMD_DESEL;
        end else begin
            case ({pins_i.ras_n, pins_i.cas_n, pins_i.we_n})
                3'b111:  cmd_o = CMD_NOP;
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_READ;
                3'b100:  cmd_o = CMD_WRITE;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = pins_i.cke ? CMD_REF : CMD_OTHER;
                default: cmd_o = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/dct_bank.sv
module dct_bank
    import dct_pkg::*;
#(
    parameter int ROW_W = ROW_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd_i,
    input  logic             sel_i,
    input  logic             ap_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [CNT_W-1:0] blen_i,
    output bank_st_e         state_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             viol_o
);
    bank_st_e         st_q, st_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ap_q, ap_d;
    logic             bursting;

    assign bursting = (st_q == BK_READ) || (st_q == BK_WRITE);

    // Offending commands are flagged here and ignored below.
    assign viol_o = sel_i &&
                    ((is_column(cmd_i) && (st_q == BK_IDLE)) ||
                     ((cmd_i == CMD_ACT) && (st_q != BK_IDLE)));

    always_comb begin
        st_d  = st_q;
        row_d = row_q;
        cnt_d = cnt_q;
        ap_d  = ap_q;

        if (bursting) begin
            if (cnt_q <= CNT_W'(1)) begin
                st_d  = ap_q ? BK_IDLE : BK_ACTIVE;
                cnt_d = '0;
                ap_d  = 1'b0;
                if (ap_q) row_d = '0;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end

        case (cmd_i)
            CMD_ACT: begin
                if (sel_i && (st_q == BK_IDLE)) begin
                    st_d  = BK_ACTIVE;
                    row_d = row_i;
                end
            end
            CMD_READ, CMD_WRITE: begin
                if (sel_i && (st_q != BK_IDLE)) begin
                    st_d  = (cmd_i == CMD_READ) ? BK_READ : BK_WRITE;
                    cnt_d = blen_i;
                    ap_d  = ap_i;
                end
            end
            CMD_PRE, CMD_REF: begin
                if ((cmd_i == CMD_REF) || sel_i || ap_i) begin
                    st_d  = BK_IDLE;
                    row_d = '0;
                    cnt_d = '0;
                    ap_d  = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            row_q <= '0;
            cnt_q <= '0;
            ap_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            row_q <= row_d;
            cnt_q <= cnt_d;
            ap_q  <= ap_d;
        end
    end

    assign state_o    = st_q;
    assign open_row_o = row_q;
endmodule

// File: rtl/dct_refcnt.sv
module dct_refcnt #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] next_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
            addr_o <= '0;
            req_o  <= 1'b0;
        end else begin
            req_o <= fire_i;
            if (fire_i) begin
                addr_o <= next_q;
                next_q <= next_q + ADDR_W'(1);
            end
        end
    end
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
    import dct_pkg::*;
#(
    parameter  int NUM_BANKS = NUM_BANKS_DEF,
    parameter  int ROW_W     = ROW_W_DEF,
    localparam int BA_W      = $clog2(NUM_BANKS),
    localparam int REF_W     = BA_W + ROW_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [BA_W-1:0]            ba_i,
    input  logic [ROW_W-1:0]           addr_i,
    input  logic [1:0]                 bl_sel_i,
    output logic [2:0]                 cmd_o,
    output logic [N_STB-1:0]           cmd_stb_o,
    output logic [2*NUM_BANKS-1:0]     bank_state_o,
    output logic [ROW_W*NUM_BANKS-1:0] open_row_o,
    output logic                       ref_req_o,
    output logic [REF_W-1:0]           ref_addr_o,
    output logic                       viol_o
);
    pins_t            pins;
    cmd_e             cmd_now;
    cmd_e             cmd_q;
    logic [N_STB-1:0] stb_q;
    logic             viol_q;
    logic [CNT_W-1:0] blen_cyc;

    bank_st_e         bank_st  [NUM_BANKS];
    logic [ROW_W-1:0] bank_row [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_viol;
    logic             any_open;
    logic             viol_d;

    assign pins     = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n, cke: cke};
    assign blen_cyc = burst_cycles(bl_sel_i);

    dct_decoder u_dec (
        .pins_i (pins),
        .cmd_o  (cmd_now)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dct_bank #(.ROW_W(ROW_W)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .cmd_i      (cmd_now),
            .sel_i      (ba_i == BA_W'(b)),
            .ap_i       (addr_i[AP_BIT]),
            .row_i      (addr_i),
            .blen_i     (blen_cyc),
            .state_o    (bank_st[b]),
            .open_row_o (bank_row[b]),
            .viol_o     (bank_viol[b])
        );
        assign bank_state_o[2*b +: 2]       = bank_st[b];
        assign open_row_o[ROW_W*b +: ROW_W] = bank_row[b];
    end

    always_comb begin
        any_open = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_st[b] != BK_IDLE) any_open = 1'b1;
        end
    end

    assign viol_d = (|bank_viol) || ((cmd_now == CMD_REF) && any_open);

    dct_refcnt #(.ADDR_W(REF_W)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .fire_i (cmd_now == CMD_REF),
        .req_o  (ref_req_o),
        .addr_o (ref_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_DESEL;
            stb_q  <= '0;
            viol_q <= 1'b0;
        end else begin
            cmd_q  <= cmd_now;
            stb_q  <= cmd_strobe(cmd_now);
            viol_q <= viol_d;
        end
    end

    assign cmd_o     = cmd_q;
    assign cmd_stb_o = stb_q;
    assign viol_o    = viol_q;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int REF_W     = 15
) (
    input logic                       clk,
    input logic                       rst,
    input logic [2:0]                 cmd_o,
    input logic [4:0]                 cmd_stb_o,
    input logic [2*NUM_BANKS-1:0]     bank_state_o,
    input logic [ROW_W*NUM_BANKS-1:0] open_row_o,
    input logic                       ref_req_o,
    input logic [REF_W-1:0]           ref_addr_o,
    input logic                       viol_o
);
    // R2
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb_o));

    // R9
    viol_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (cmd_o == 3'd2 || cmd_o == 3'd3 || cmd_o == 3'd4 || cmd_o == 3'd6));

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'd0) |-> (cmd_stb_o == '0 && !viol_o));

    // R8
    ref_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req_o |-> (bank_state_o == '0 && cmd_stb_o[4]));

    // R8
    ref_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_req_o |-> $stable(ref_addr_o));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
        // R10
        idle_row_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (bank_state_o[2*b +: 2] == 2'd0) |-> (open_row_o[ROW_W*b +: ROW_W] == '0));
    end
endmodule

bind dram_cmd_tracker dct_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .REF_W     (REF_W)
) u_dct_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_o        (cmd_o),
    .cmd_stb_o    (cmd_stb_o),
    .bank_state_o (bank_state_o),
    .open_row_o   (open_row_o),
    .ref_req_o    (ref_req_o),
    .ref_addr_o   (ref_addr_o),
    .viol_o       (viol_o)
);

// File: tb/dram_cmd_tracker_bench.sv
module dram_cmd_tracker_bench;
    localparam int NB  = 4;
    localparam int RW  = 13;
    localparam int BW  = 2;
    localparam int RFW = BW + RW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [BW-1:0] ba = '0;
    logic [RW-1:0] addr = '0;
    logic [1:0]    bl_sel = 2'b00;

    logic [2:0]       cmd_o;
    logic [4:0]       cmd_stb_o;
    logic [2*NB-1:0]  bank_state_o;
    logic [RW*NB-1:0] open_row_o;
    logic             ref_req_o;
    logic [RFW-1:0]   ref_addr_o;
    logic             viol_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_st[NB], m_row[NB], m_cnt[NB], m_ap[NB];
    int m_refnext = 0;
    int e_cmd = 0, e_stb = 0, e_viol = 0, e_ref = 0, e_refaddr = 0;

    always #5 clk = ~clk;

    dram_cmd_tracker u_dram_cmd_tracker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba_i(ba), .addr_i(addr), .bl_sel_i(bl_sel),
        .cmd_o(cmd_o), .cmd_stb_o(cmd_stb_o), .bank_state_o(bank_state_o),
        .open_row_o(open_row_o), .ref_req_o(ref_req_o), .ref_addr_o(ref_addr_o),
        .viol_o(viol_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int st_of(int b);
        return int'(bank_state_o[2*b +: 2]);
    endfunction

    function automatic int row_of(int b);
        return int'(open_row_o[RW*b +: RW]);
    endfunction

    // Model: decide what the pins mean and how the banks react.
    task automatic model_step();
        int c;
        int beats;
        bit any_open;
        bit ap;
        ap = addr[10];
        if (cs_n) c = 0;
        else if ({ras_n, cas_n, we_n} == 3'b111) c = 1;
        else if ({ras_n, cas_n, we_n} == 3'b011) c = 2;
        else if ({ras_n, cas_n, we_n} == 3'b101) c = 3;
        else if ({ras_n, cas_n, we_n} == 3'b100) c = 4;
        else if ({ras_n, cas_n, we_n} == 3'b010) c = 5;
        else if ({ras_n, cas_n, we_n} == 3'b001 && cke) c = 6;
        else c = 7;
        beats = (bl_sel == 2'b00) ? 2 : (bl_sel == 2'b01) ? 4 : 8;

        any_open = 0;
        foreach (m_st[b]) if (m_st[b] != 0) any_open = 1;
        e_viol = 0;
        if ((c == 3 || c == 4) && m_st[ba] == 0) e_viol = 1;
        if (c == 2 && m_st[ba] != 0) e_viol = 1;
        if (c == 6 && any_open) e_viol = 1;
        e_cmd = c;
        e_stb = (c >= 2 && c <= 6) ? (1 << (c - 2)) : 0;
        e_ref = (c == 6);

        foreach (m_st[b]) begin
            if (m_st[b] == 2 || m_st[b] == 3) begin
                m_cnt[b]--;
                if (m_cnt[b] == 0) begin
                    if (m_ap[b] != 0) begin m_st[b] = 0; m_row[b] = 0; end
                    else m_st[b] = 1;
                    m_ap[b] = 0;
                end
            end
        end
        if (c == 2 && !e_viol) begin m_st[ba] = 1; m_row[ba] = int'(addr); end
        if ((c == 3 || c == 4) && !e_viol) begin
            m_st[ba] = (c == 3) ? 2 : 3; m_cnt[ba] = beats / 2; m_ap[ba] = ap;
        end
        foreach (m_st[b]) begin
            if (c == 6 || (c == 5 && (ap || b == int'(ba)))) begin
                m_st[b] = 0; m_row[b] = 0; m_cnt[b] = 0; m_ap[b] = 0;
            end
        end
        if (c == 6) begin e_refaddr = m_refnext; m_refnext++; end
    endtask

    task automatic compare_all();
        check("R2 cmd_o", cmd_o, e_cmd);
        check("R2 cmd_stb_o", cmd_stb_o, e_stb);
        check("R9 viol_o", viol_o, e_viol);
        check("R8 ref_req_o", ref_req_o, e_ref);
        check("R8 ref_addr_o", ref_addr_o, e_refaddr);
        for (int b = 0; b < NB; b++) begin
            check("R4 bank_state", st_of(b), m_st[b]);
            check("R10 open_row", row_of(b), m_row[b]);
        end
    endtask

    // Inputs are set at a falling edge; the next rising edge samples them.
    task automatic drive(input bit c, input bit r, input bit ca, input bit w,
                         input bit k, input int b, input int a);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k;
        ba = BW'(b); addr = RW'(a);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic nop();                  drive(0,1,1,1,1,0,0); endtask
    task automatic act(int b, int row);    drive(0,0,1,1,1,b,row); endtask
    task automatic rd(int b, bit ap);      drive(0,1,0,1,1,b,ap ? 32'h400 : 0); endtask
    task automatic wr(int b, bit ap);      drive(0,1,0,0,1,b,ap ? 32'h400 : 0); endtask
    task automatic pre(int b, bit all);    drive(0,0,1,0,1,b,all ? 32'h400 : 0); endtask
    task automatic refresh();              drive(0,0,0,1,1,0,0); endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        foreach (m_st[b]) begin m_st[b] = 0; m_row[b] = 0; m_cnt[b] = 0; m_ap[b] = 0; end
        repeat (3) @(negedge clk);
        // R11 reset values while reset is held
        check("R11 cmd", cmd_o, 0);
        check("R11 stb", cmd_stb_o, 0);
        check("R11 state", bank_state_o, 0);
        check("R11 rows", open_row_o, 0);
        check("R11 refaddr", ref_addr_o, 0);
        check("R11 viol", viol_o, 0);
        rst = 1'b0;

        // R1 deselect with command pins low, then NOP
        drive(1,0,0,0,1,0,0);
        check("R1 deselect code", cmd_o, 0);
        nop();
        check("R1 nop code", cmd_o, 1);

        // R3 activate
        act(0, 13'h1ABC);
        check("R3 active", st_of(0), 1);
        check("R3 row", row_of(0), 13'h1ABC);

        // R4 burst lengths
        bl_sel = 2'b00; rd(0, 0);
        check("R4 read state", st_of(0), 2);
        nop();
        check("R4 BL2 done", st_of(0), 1);
        bl_sel = 2'b01; wr(0, 0);
        nop();
        check("R4 BL4 still writing", st_of(0), 3);
        nop();
        check("R4 BL4 done", st_of(0), 1);

        // R5 auto-precharge with 8 beats
        bl_sel = 2'b10; rd(0, 1);
        repeat (3) nop();
        check("R5 still reading", st_of(0), 2);
        nop();
        check("R5 idle after burst", st_of(0), 0);
        check("R5 row cleared", row_of(0), 0);

        // R9 read to idle bank, double activate
        rd(1, 0);
        check("R9 read idle viol", viol_o, 1);
        check("R9 read idle ignored", st_of(1), 0);
        act(1, 13'h0123);
        act(1, 13'h0456);
        check("R9 act busy viol", viol_o, 1);
        check("R9 row kept", row_of(1), 13'h0123);

        // R7 precharge cuts burst
        act(2, 13'h0777);
        bl_sel = 2'b11; wr(2, 0);
        nop();
        pre(2, 0);
        check("R7 burst cut", st_of(2), 0);

        // R6 single and all-bank precharge, precharge to idle bank
        act(3, 13'h0999);
        act(2, 13'h0555);
        pre(3, 0);
        check("R6 single closes target", st_of(3), 0);
        check("R6 single keeps other", st_of(2), 1);
        pre(3, 0);
        check("R6 pre idle no viol", viol_o, 0);
        act(0, 13'h0042);
        pre(0, 1);
        check("R6 all closed", bank_state_o, 0);

        // R8 refresh, with and without open banks
        act(1, 13'h0011);
        refresh();
        check("R9 refresh open viol", viol_o, 1);
        check("R8 all idle", bank_state_o, 0);
        check("R8 first addr", ref_addr_o, 0);
        refresh();
        check("R8 second addr", ref_addr_o, 1);
        check("R8 no viol", viol_o, 0);

        // R12 restarted burst
        act(0, 13'h0100);
        bl_sel = 2'b10; rd(0, 1);
        nop();
        wr(0, 0);
        repeat (3) nop();
        check("R12 writing", st_of(0), 3);
        nop();
        check("R12 back active", st_of(0), 1);

        // R2 undefined patterns leave state
        drive(0,0,0,1,0,0,0);
        check("R2 self-refresh pattern other", cmd_o, 7);
        drive(0,0,0,0,1,0,0);
        drive(0,1,1,0,1,0,0);
        check("R2 other no effect", st_of(0), 1);

        // random activity
        for (int i = 0; i < 2000; i++) begin
            int k;
            k = $urandom_range(0, 15);
            bl_sel = 2'($urandom);
            case (k)
                0, 1:    act($urandom_range(0,3), $urandom_range(0, 8191));
                2, 3:    rd($urandom_range(0,3), 1'($urandom));
                4, 5:    wr($urandom_range(0,3), 1'($urandom));
                6:       pre($urandom_range(0,3), ($urandom_range(0,3) == 0));
                7:       refresh();
                8:       drive(1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                               $urandom_range(0,3), $urandom_range(0, 8191));
                9:       drive(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                               $urandom_range(0,3), $urandom_range(0, 8191));
                default: nop();
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule